// File: doc/BRIEF.md
# Receive Byte Queue with Trigger and Character-Timeout Interrupts

This block sits on the receive side of a 16550-style serial port. It sits between the deserializer and the host's holding-register read path. Each completed character from the deserializer is written into a byte queue, 16 entries deep by default. The character arrives with a strobe that marks the centre of its stop bit. Each host read of the holding register removes the oldest byte, and that byte is always shown on `rd_data`. When the queue is switched off, the block acts as a single holding register.

Two interrupt sources share one priority level and one enable. The data-available source is active while the fill level is at or above a trigger level chosen by the host. The character-timeout source fires when bytes sit in the queue with no new stop bit and no read. The length of that wait is 4·P+12 bit times, where P is the programmed word length. The block puts out a data-ready flag, a sticky overrun flag, an interrupt request and a 4-bit identification code.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the queue is empty, and `data_ready`, `overrun` and `irq` are 0. `iid` is 4'b0001, meaning nothing pending.
- R2: With `fifo_en`=1 up to DEPTH bytes are held in arrival order. `rd_data` always shows the oldest byte, and a `rd_pop` pulse removes it.
- R3: A byte that arrives when the queue is full is discarded and sets `overrun`. Full means DEPTH bytes with `fifo_en`=1, or 1 byte with `fifo_en`=0. `overrun` clears on the next accepted read. A write and a read in the same cycle on a full queue are both accepted.
- R4: `data_ready` is 1 exactly when the queue holds at least one byte.
- R5: `trig_sel` codes 0,1,2,3 select trigger levels of 1, 4, 8 and 14 bytes. When the level is at or above the trigger and `ier_rx`=1, `irq`=1 and `iid`=4'b0100.
- R6: The data-available indication drops once a read brings the level below the trigger.
- R7: `word_len` codes 0..3 mean P = 5..8 data bits. The timeout fires on the (4·P+12)-th `bit_tick` after the last restart. For example, code 2 gives 40 ticks.
- R8: The timeout count restarts on every `stop_mid` pulse and on every `rd_pop`.
- R9: No timeout is signalled while the queue is empty, and none is signalled with `fifo_en`=0.
- R10: A pending timeout gives `iid`=4'b1100. This code takes precedence over 4'b0100. A pending timeout is cleared only by a read.
- R11: With `ier_rx`=0, `irq`=0 and `iid`=4'b0001. Pending conditions are kept and reappear when the enable returns.
- R12: With `fifo_en`=0 the trigger level is fixed at 1 byte.
- R13: A `rd_pop` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| trig_sel | input | 2 | Trigger level select (1/4/8/14 bytes) |
| word_len | input | 2 | Word length code, P = 5 + code |
| ier_rx | input | 1 | Enable for both receive interrupt sources |
| bit_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| stop_mid | input | 1 | Stop-bit centre strobe |
| rd_pop | input | 1 | Host read of the holding register |
| rd_data | output | DATA_W | Oldest byte in the queue |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky lost-byte flag |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Interrupt identification code |

## Verification
Several pairs of functions can act in the same clock cycle. A write and a read can land together on a full queue. The bench provokes this by pulsing `rx_valid` and `rd_pop` together with 16 bytes held. It judges the result through the scoreboard order and by checking that `overrun` stays low. A timeout can also be pending while a new byte raises the level past the trigger. In that case `iid` must keep reporting 4'b1100 until a read. After the read, the level is still at the trigger, so `iid` must fall back to 4'b0100.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_DATA = 4'b0100,
      IID_TMO  = 4'b1100
   } iid_e;

   // trigger level in bytes for a 2-bit select code
   function automatic int unsigned trig_bytes(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   // timeout length in bit times for a word-length code
   function automatic int unsigned tmo_bits(input logic [1:0] code, input int unsigned min_word);
      return 4 * (min_word + int'(code)) + 12;
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  level,
   output logic              ovr
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr, wnext, rnext;
   logic              full, pop_ok, push_ok;

   assign full    = single ? (level != '0) : (level == CNT_W'(DEPTH));
   assign pop_ok  = pop && (level != '0);
   assign push_ok = push && (!full || pop_ok);
   assign dout    = mem[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_mod
         assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         ovr   <= 1'b0;
      end else begin
         if (push_ok) wptr <= wnext;
         if (pop_ok)  rptr <= rnext;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && !push_ok) ovr <= 1'b1;
         else if (pop_ok)      ovr <= 1'b0;
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));
   a_r3_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> ovr);
   a_r13_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && level == '0 && !push) |=> level == '0);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(level));

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
   parameter int MIN_WORD = 5,
   localparam int TMO_W = $clog2(4 * (MIN_WORD + 3) + 12 + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic [1:0] word_len,
   input  logic       active,
   input  logic       restart,
   input  logic       rd_clr,
   output logic       to_flag
);
   import rxq_pkg::*;

   logic [TMO_W-1:0] cnt, lim;
   logic             expire;

   assign lim    = TMO_W'(tmo_bits(word_len, MIN_WORD));
   assign expire = active && bit_tick && !restart && (cnt == lim - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         to_flag <= 1'b0;
      end else begin
         if (!active || restart)        cnt <= '0;
         else if (bit_tick && cnt < lim) cnt <= cnt + 1'b1;

         if (!active || rd_clr) to_flag <= 1'b0;
         else if (expire)       to_flag <= 1'b1;
      end
   end

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == '0);
   a_r7_fire_point: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> ($past(cnt) == $past(lim) - 1'b1));

endmodule

// File: rtl/rxq_intr.sv
module rxq_intr #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level,
   input  logic [1:0]       trig_sel,
   input  logic             fifo_en,
   input  logic             ier,
   input  logic             to_flag,
   output logic             irq,
   output logic [3:0]       iid
);
   import rxq_pkg::*;

   logic [CNT_W-1:0] trig;
   logic             hit;
   iid_e             code;

   assign trig = fifo_en ? CNT_W'(trig_bytes(trig_sel)) : CNT_W'(1);
   assign hit  = level >= trig;

   always_comb begin
      code = IID_NONE;
      if (ier) begin
         if (to_flag)  code = IID_TMO;
         else if (hit) code = IID_DATA;
      end
   end

   assign iid = code;
   assign irq = (code != IID_NONE);

   a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> level != '0);
   a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !ier |-> !irq);

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter int MIN_WORD = 5,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic [1:0]        trig_sel,
   input  logic [1:0]        word_len,
   input  logic              ier_rx,
   input  logic              bit_tick,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              stop_mid,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              overrun,
   output logic              irq,
   output logic [3:0]        iid
);

   generate
      if (DEPTH < 14) begin : g_bad_depth
         $error("DEPTH must hold the largest trigger level (14)");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (MIN_WORD < 1) begin : g_bad_word
         $error("MIN_WORD must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] level;
   logic             to_flag;

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .single(!fifo_en),
      .push  (rx_valid),
      .din   (rx_data),
      .pop   (rd_pop),
      .dout  (rd_data),
      .level (level),
      .ovr   (overrun)
   );

   rxq_timeout #(.MIN_WORD(MIN_WORD)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_tick(bit_tick),
      .word_len(word_len),
      .active  (fifo_en && level != '0),
      .restart (stop_mid || rd_pop),
      .rd_clr  (rd_pop),
      .to_flag (to_flag)
   );

   rxq_intr #(.CNT_W(CNT_W)) u_intr (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (level),
      .trig_sel(trig_sel),
      .fifo_en (fifo_en),
      .ier     (ier_rx),
      .to_flag (to_flag),
      .irq     (irq),
      .iid     (iid)
   );

   assign data_ready = (level != '0);

   a_r10_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> data_ready);
   a_r12_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && $past(!fifo_en) && $past(level) <= 1 |-> level <= 1);

endmodule

// File: tb/tb_uart_rx_fifo_irq.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic [1:0] word_len = 2'd2;
   logic       ier_rx = 1'b0;
   logic       bit_tick = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       stop_mid = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       data_ready, overrun, irq;
   logic [3:0] iid;

   int checks = 0;
   int fails  = 0;
   logic [7:0] sbq[$];

   always #2.5 clk = ~clk;

   uart_rx_fifo_irq dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // driver: a received byte with its stop-bit centre strobe
   task automatic push(input logic [7:0] d);
      int cap = fifo_en ? 16 : 1;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; stop_mid = 1'b1;
      if (sbq.size() < cap) sbq.push_back(d);
      @(negedge clk);
      rx_valid = 1'b0; stop_mid = 1'b0;
   endtask

   // monitor: compare the oldest byte against the scoreboard and pop
   task automatic read_cmp(input string tag);
      @(negedge clk);
      if (sbq.size() > 0) chk(tag, rd_data, sbq.pop_front());
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic push_pop(input logic [7:0] d);
      @(negedge clk);
      chk("R3 simultaneous data", rd_data, sbq.pop_front());
      sbq.push_back(d);
      rx_valid = 1'b1; rx_data = d; stop_mid = 1'b1; rd_pop = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; stop_mid = 1'b0; rd_pop = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bit_tick = 1'b1;
         @(negedge clk); bit_tick = 1'b0;
      end
   endtask

   task automatic stop_pulse();
      @(negedge clk); stop_mid = 1'b1;
      @(negedge clk); stop_mid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 data_ready", data_ready, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 irq", irq, 0);
      chk("R1 iid", iid, 4'b0001);

      // R5/R6 trigger of 8
      fifo_en = 1'b1; trig_sel = 2'd2; ier_rx = 1'b1; word_len = 2'd2;
      for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
      chk("R4 data_ready", data_ready, 1);
      chk("R5 below trigger iid", iid, 4'b0001);
      push(8'h17);
      chk("R5 trigger 8 irq", irq, 1);
      chk("R5 trigger 8 iid", iid, 4'b0100);
      read_cmp("R2 order");
      chk("R6 below trigger iid", iid, 4'b0001);
      while (sbq.size() > 0) read_cmp("R2 order");
      chk("R4 empty", data_ready, 0);

      // R13 pop on empty
      read_cmp("R13 empty pop");
      chk("R13 still empty", data_ready, 0);
      trig_sel = 2'd0;
      push(8'h5A);
      chk("R5 trigger 1 iid", iid, 4'b0100);
      read_cmp("R13 data after empty pop");
      chk("R13 empty again", data_ready, 0);

      // R3/R5 trigger 14, overflow, simultaneous write and read
      trig_sel = 2'd3;
      for (int i = 0; i < 13; i++) push(8'h80 + 8'(i));
      chk("R5 level 13 iid", iid, 4'b0001);
      push(8'h8D);
      chk("R5 trigger 14 iid", iid, 4'b0100);
      push(8'h8E); push(8'h8F);
      push_pop(8'h90);
      chk("R3 no overrun on simultaneous", overrun, 0);
      push(8'hEE);
      chk("R3 overrun set", overrun, 1);
      read_cmp("R3 order after drop");
      chk("R3 overrun cleared", overrun, 0);
      while (sbq.size() > 0) read_cmp("R2 order full");

      // R7/R9/R10 timeout
      trig_sel = 2'd1;
      ticks(60);
      chk("R9 empty no timeout", iid, 4'b0001);
      push(8'hA0);
      ticks(39);
      chk("R7 before 40 ticks", iid, 4'b0001);
      ticks(1);
      chk("R7 at 40 ticks iid", iid, 4'b1100);
      chk("R7 irq", irq, 1);
      read_cmp("R10 data");
      chk("R10 cleared by read", iid, 4'b0001);

      // R8 restart by stop-bit centre, word length code 0 (32)
      word_len = 2'd0;
      push(8'hA1); push(8'hA2);
      ticks(20);
      stop_pulse();
      ticks(31);
      chk("R8 restart stop_mid", iid, 4'b0001);
      ticks(1);
      chk("R8 fire 32 after restart", iid, 4'b1100);
      push(8'hA3); push(8'hA4); push(8'hA5);
      chk("R10 precedence", iid, 4'b1100);
      ier_rx = 1'b0;
      @(negedge clk);
      chk("R11 irq gated", irq, 0);
      chk("R11 iid gated", iid, 4'b0001);
      ier_rx = 1'b1;
      @(negedge clk);
      chk("R11 restored", iid, 4'b1100);
      read_cmp("R10 data");
      chk("R6 level 4 after read", iid, 4'b0100);
      ticks(31);
      chk("R8 restart by read", iid, 4'b0100);
      ticks(1);
      chk("R8 fire after read restart", iid, 4'b1100);
      while (sbq.size() > 0) read_cmp("R2 drain");

      // R12 single holding register
      fifo_en = 1'b0; trig_sel = 2'd3;
      push(8'hC1);
      chk("R12 trigger 1", iid, 4'b0100);
      push(8'hC2);
      chk("R3 single overrun", overrun, 1);
      ticks(100);
      chk("R9 no timeout disabled", iid, 4'b0100);
      read_cmp("R12 holds first byte");
      chk("R12 empty", data_ready, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule